// File: doc/BRIEF.md
# Interrupt Flag and Vector Unit

This block keeps the pending-interrupt flags of a serial peripheral together with one enable bit per source. Four sources are held, ranked by priority: transmit-buffer-empty (lowest), transmit-done, start-detected and receive-full (highest). A small register bus reads and writes the flag and enable registers. It also offers a read-only vector register. That register returns an even numeric code for the highest-priority source that is both pending and enabled.

Reading the vector clears the flag of the source it names, so a handler can dispatch with one read. Software may set or clear any flag by writing the flag register. Hardware set pulses from the peripheral merge with software writes in the same cycle, so a set event is never dropped. Hardware clear pulses, such as a write to the transmit holding buffer, drop a flag. The combined interrupt request is registered.

Top module: `irq_flag_vector`

## Requirements
- R1: Out of reset the flag register reads 4'b0001 (only transmit-empty, bit 0, is pending), the enable register reads 0, `irq` is 0 and `rdData` is 0.
- R2: The vector code is 0 when no source has both its flag and enable set. Otherwise it is 2×(i+1) for the highest such bit index i, where bit 0 = transmit-empty, bit 1 = transmit-done, bit 2 = start-detected and bit 3 = receive-full.
- R3: A read of the vector register (address 2) clears the flag of the source whose code it returns, and leaves every other flag as it was. A vector read that returns 0 changes no flag.
- R4: A `hwSet` pulse on bit i leaves flag i at 1 after that edge, whatever software write, vector-read clear or `hwClr` pulse happens in the same cycle.
- R5: A write to the flag register (address 0) sets each bit written as 1 and clears each bit written as 0, except bits that get a `hwSet` pulse in the same cycle.
- R6: A `hwClr` pulse on bit i clears flag i, unless the same cycle brings a `hwSet` on bit i or a flag-register write of 1 to bit i.
- R7: The enable register (address 1) is written and read back on its low 4 bits. A flag still sets and stays set while its enable is 0.
- R8: `irq` is 1 in the cycle after any source had both flag and enable set, and 0 in the cycle after none had.
- R9: Read data appears on `rdData` one cycle after `busRd` and holds until the next read. It shows the register contents before that cycle's updates. Address 3 reads 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register select: 0 flags, 1 enables, 2 vector, 3 reserved |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| hwSet | input | 4 | Per-source hardware set pulses |
| hwClr | input | 4 | Per-source hardware clear pulses (bit 0 = transmit buffer written) |
| rdData | output | 8 | Registered read data |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach from the ports is a collision on a single edge. In it, a vector read clears a flag while a hardware set pulse on that same source arrives, or a flag-register write of 0 meets a set pulse on a bit it would clear. Random stimulus seldom lines these up, so directed steps build each collision with known flag and enable contents and then read the flag register back. Long random runs with sparse set pulses and frequent vector reads then cover the mixed orderings. A bench model predicts every read and every `irq` value.

// File: rtl/ifv_pkg.sv
package ifv_pkg;
  localparam logic [1:0] ADDR_FLAGS   = 2'd0;
  localparam logic [1:0] ADDR_ENABLES = 2'd1;
  localparam logic [1:0] ADDR_VECTOR  = 2'd2;

  typedef struct packed {
    logic wrFlags;
    logic wrEnables;
    logic rdFlags;
    logic rdEnables;
    logic rdVector;
    logic rdAny;
  } ifv_strobe_t;
endpackage

// File: rtl/ifv_prio_enc.sv
module ifv_prio_enc #(
  parameter int NUM_SRC = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CODE_W = $clog2(2 * NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] active,
  output logic               anyActive,
  output logic [IDX_W-1:0]   topIdx,
  output logic [CODE_W-1:0]  topCode
);
  always_comb begin
    anyActive = 1'b0;
    topIdx    = '0;
    topCode   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i]) begin
        anyActive = 1'b1;
        topIdx    = IDX_W'(i);
        topCode   = CODE_W'(2 * (i + 1));
      end
    end
  end
endmodule

// File: rtl/ifv_ctrl.sv
module ifv_ctrl
  import ifv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  output ifv_strobe_t strobes
);
  always_comb begin
    strobes           = '0;
    strobes.wrFlags   = busWr && (busAddr == ADDR_FLAGS);
    strobes.wrEnables = busWr && (busAddr == ADDR_ENABLES);
    strobes.rdFlags   = busRd && (busAddr == ADDR_FLAGS);
    strobes.rdEnables = busRd && (busAddr == ADDR_ENABLES);
    strobes.rdVector  = busRd && (busAddr == ADDR_VECTOR);
    strobes.rdAny     = busRd;
  end

  // R9: at most one write target and one read target per cycle
  assert_one_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrFlags, strobes.wrEnables}));
  assert_one_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.rdFlags, strobes.rdEnables, strobes.rdVector}));
endmodule

// File: rtl/ifv_datapath.sv
module ifv_datapath
  import ifv_pkg::*;
#(
  parameter int            NUM_SRC    = 4,
  parameter int            DATA_W     = 8,
  parameter logic [NUM_SRC-1:0] FLAG_RESET = 4'b0001,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int CODE_W = $clog2(2 * NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ifv_strobe_t        strobes,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] hwSet,
  input  logic [NUM_SRC-1:0] hwClr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  logic [NUM_SRC-1:0] flags, enables, flagsNext, vecClr;
  logic               anyActive;
  logic [IDX_W-1:0]   topIdx;
  logic [CODE_W-1:0]  topCode;

  ifv_prio_enc #(.NUM_SRC(NUM_SRC)) uPrio (
    .active   (flags & enables),
    .anyActive(anyActive),
    .topIdx   (topIdx),
    .topCode  (topCode)
  );

  always_comb begin
    vecClr = '0;
    if (strobes.rdVector && anyActive) vecClr[topIdx] = 1'b1;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : gFlag
    always_comb begin
      if (hwSet[i])                          flagsNext[i] = 1'b1;
      else if (strobes.wrFlags && wdata[i])  flagsNext[i] = 1'b1;
      else if (strobes.wrFlags)              flagsNext[i] = 1'b0;
      else if (hwClr[i] || vecClr[i])        flagsNext[i] = 1'b0;
      else                                   flagsNext[i] = flags[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags   <= FLAG_RESET;
      enables <= '0;
      irq     <= 1'b0;
      rdData  <= '0;
    end else begin
      flags <= flagsNext;
      if (strobes.wrEnables) enables <= wdata[NUM_SRC-1:0];
      irq <= |(flags & enables);
      if (strobes.rdAny) begin
        if (strobes.rdFlags)        rdData <= DATA_W'(flags);
        else if (strobes.rdEnables) rdData <= DATA_W'(enables);
        else if (strobes.rdVector)  rdData <= DATA_W'(topCode);
        else                        rdData <= '0;
      end
    end
  end

  assert_hwset_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|hwSet) |=> ((flags & $past(hwSet)) == $past(hwSet)));
  assert_vec_even_R2: assert property (@(posedge clk) disable iff (!rstN)
    (topCode[0] == 1'b0) && (anyActive == (topCode != '0)));
  assert_vec_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdVector && anyActive && !strobes.wrFlags && !hwSet[topIdx])
      |=> !flags[$past(topIdx)]);
  assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrEnables |=> $stable(enables));
  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyActive |=> irq);
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !anyActive |=> !irq);
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdAny |=> $stable(rdData));
endmodule

// File: rtl/irq_flag_vector.sv
module irq_flag_vector
  import ifv_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] hwSet,
  input  logic [NUM_SRC-1:0] hwClr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irq
);
  ifv_strobe_t strobes;

  ifv_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWr  (busWr),
    .busRd  (busRd),
    .strobes(strobes)
  );

  ifv_datapath #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .FLAG_RESET(NUM_SRC'(1))
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wdata  (busWdata),
    .hwSet  (hwSet),
    .hwClr  (hwClr),
    .rdData (rdData),
    .irq    (irq)
  );
endmodule

// File: tb/irq_flag_vector_test.sv
module irq_flag_vector_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [3:0] hwSet = '0, hwClr = '0;
  logic [7:0] rdData;
  logic       irq;

  int checks = 0, fails = 0;
  logic [3:0] mf, me;
  bit done = 0;

  always #4 clk = ~clk;

  irq_flag_vector uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .hwSet(hwSet), .hwClr(hwClr), .rdData(rdData), .irq(irq)
  );

  function automatic logic [7:0] vecCode(logic [3:0] f, logic [3:0] e);
    logic [7:0] c = 0;
    for (int i = 0; i < 4; i++) if (f[i] && e[i]) c = 8'(2 * (i + 1));
    return c;
  endfunction

  function automatic logic [3:0] nextFlags(logic [3:0] f, logic [3:0] e, logic [1:0] a,
      logic w, logic r, logic [7:0] wd, logic [3:0] hs, logic [3:0] hc);
    logic [3:0] n;
    logic [3:0] vc = 0;
    logic [7:0] c = vecCode(f, e);
    if (r && a == 2 && c != 0) vc[(c >> 1) - 1] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (hs[i]) n[i] = 1;
      else if (w && a == 0) n[i] = wd[i];
      else if (hc[i] || vc[i]) n[i] = 0;
      else n[i] = f[i];
    end
    return n;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic w, input logic r, input logic [7:0] wd,
      input logic [3:0] hs, input logic [3:0] hc, input string tag);
    logic expIrq = |(mf & me);
    logic [7:0] expRd;
    case (a)
      2'd0: expRd = {4'b0, mf};
      2'd1: expRd = {4'b0, me};
      2'd2: expRd = vecCode(mf, me);
      default: expRd = 8'h00;
    endcase
    busAddr = a; busWr = w; busRd = r; busWdata = wd; hwSet = hs; hwClr = hc;
    @(posedge clk);
    mf = nextFlags(mf, me, a, w, r, wd, hs, hc);
    if (w && a == 1) me = wd[3:0];
    @(negedge clk);
    busWr = 0; busRd = 0; hwSet = 0; hwClr = 0;
    check({"R8 irq ", tag}, {7'b0, irq}, {7'b0, expIrq});
    if (r) check({"R9 read ", tag}, rdData, expRd);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, "idle"); endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    mf = 4'b0001; me = 4'b0000;
    // R1 reset state
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    check("R1 rdData after reset", rdData, 8'h00);
    step(0, 0, 1, 0, 0, 0, "R1 flags reset");
    check("R1 flags value", rdData, 8'h01);
    step(1, 0, 1, 0, 0, 0, "R1 enables reset");
    check("R1 enables value", rdData, 8'h00);
    // R7 enable txEmpty -> irq (R8)
    step(1, 1, 0, 8'h01, 0, 0, "R7 enable tx");
    idle();
    check("R8 irq raised by tx flag", {7'b0, irq}, 8'h01);
    // R2/R3 vector read of tx clears it
    step(2, 0, 1, 0, 0, 0, "R3 vec read tx");
    check("R2 tx code", rdData, 8'h02);
    step(0, 0, 1, 0, 0, 0, "R3 flags after vec");
    check("R3 tx cleared", rdData, 8'h00);
    // R5 sw write 1 reasserts tx
    step(0, 1, 0, 8'h01, 0, 0, "R5 rewrite tx");
    step(0, 0, 1, 0, 0, 0, "R5 check");
    check("R5 tx reasserted", rdData, 8'h01);
    // R7 flag sets while disabled
    step(0, 0, 0, 0, 4'b1000, 0, "R7 rx set disabled");
    step(0, 0, 1, 0, 0, 0, "R7 readback");
    check("R7 rx pending while disabled", rdData, 8'h09);
    step(2, 0, 1, 0, 0, 0, "R2 vec disabled rx");
    check("R2 code ignores disabled", rdData, 8'h02);
    // R4 vector read clashes with hwSet on same source
    step(1, 1, 0, 8'h0F, 0, 0, "enable all");
    step(2, 0, 1, 0, 4'b1000, 0, "R4 vec read vs set");
    check("R2 rx code", rdData, 8'h08);
    step(0, 0, 1, 0, 0, 0, "R4 readback");
    check("R4 rx survives vec clear", rdData, 8'h08);
    // R4/R5 sw write 0 meets hwSet on another bit
    step(0, 1, 0, 8'h00, 4'b0100, 0, "R4 write0 vs set");
    step(0, 0, 1, 0, 0, 0, "R4 readback2");
    check("R4 start flag kept", rdData, 8'h04);
    // R6 hwClr, and sw write 1 beats hwClr
    step(0, 1, 0, 8'h01, 0, 4'b0001, "R6 write1 vs clr");
    step(0, 0, 0, 0, 0, 4'b0001, "R6 clr tx");
    step(0, 0, 1, 0, 0, 0, "R6 readback");
    check("R6 tx cleared by clr", rdData, 8'h00);
    idle();
    check("R8 irq low with nothing pending", {7'b0, irq}, 8'h00);
    step(2, 0, 1, 0, 0, 0, "R3 empty vec");
    check("R3 empty code", rdData, 8'h00);
    // R9 address 3 and writes to vector ignored
    step(2, 1, 0, 8'hFF, 0, 0, "R9 write vec");
    step(3, 1, 0, 8'hFF, 0, 0, "R9 write rsvd");
    step(3, 0, 1, 0, 0, 0, "R9 rsvd read");
    step(0, 0, 1, 0, 0, 0, "R9 flags untouched");
    step(1, 0, 1, 0, 0, 0, "R9 enables untouched");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] a = 2'($urandom);
      logic w = ($urandom % 4) == 0;
      logic r = ($urandom % 2) == 0;
      logic [7:0] wd = 8'($urandom);
      logic [3:0] hs = 4'($urandom & $urandom & $urandom);
      logic [3:0] hc = 4'($urandom & $urandom);
      step(a, w, r, wd, hs, hc, "random");
      if ((n % 16) == 0) step(0, 0, 1, 0, 0, 0, "R5 random flags");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule